// File: doc/BRIEF.md
# Operand Address Generator with Stride Modifiers and Read Formatting

This block lets a datapath fetch and store memory operands without issuing load or store instructions and without doing its own pointer arithmetic. Software programs a base pointer, up to four signed stride registers and a format mode once, before a loop. Each access request then carries a 2-bit stride select. The unit drives the current pointer onto the memory address bus in that cycle, and at the end of the cycle it stores the pointer plus the selected stride. A small stride for stepping along a row and a large stride for jumping to the next row therefore give two-dimensional traversal with no extra instructions.

Read data comes back from a synchronous memory one cycle after the request. It is reshaped on the fly into a two-lane vector of 16-bit elements. Packed byte pairs can be sign-extended to 16 bits. A single element can be copied into both lanes, for example to apply one weight to two neighbouring samples. Stores pass datapath data straight through to the memory at the generated address.

Top module: `opnd_agu`

## Requirements
- R1: After reset the pointer, all four strides and the mode are zero. `mem_re`, `mem_we` and `opnd_valid` are low, and the first access issues address 0.
- R2: In the cycle of an access (`acc_req`=1), `mem_addr` equals the current pointer. `mem_re` is high for a read (`acc_wr`=0) and `mem_we` is high for a write (`acc_wr`=1). The two strobes are never high together, and both are low when there is no access.
- R3: After an access, the pointer equals the issued address plus the stride chosen by `acc_sel` (0..3), treated as a signed 16-bit value, modulo 2^16.
- R4: In a cycle with neither an access nor a pointer write, the pointer keeps its value.
- R5: Configuration writes use `cfg_addr` 0..3 for stride 0..3, 4 for the pointer and 5 for the mode (bit 0 widen, bit 1 replicate). A configuration write in the same cycle as an access takes effect first, so the access uses the newly written pointer, stride or mode.
- R6: For every read access, `opnd_valid` is high in the following cycle and `opnd_data` is formatted from that cycle's `mem_rdata`. It uses the mode that was in effect at the access.
- R7: With mode 0, `opnd_data` equals `mem_rdata` unchanged.
- R8: With widen only, lane 0 (`opnd_data[15:0]`) is `mem_rdata[7:0]` sign-extended and lane 1 (`opnd_data[31:16]`) is `mem_rdata[15:8]` sign-extended.
- R9: With replicate only, both lanes equal `mem_rdata[15:0]`.
- R10: With widen and replicate both set, both lanes equal `mem_rdata[7:0]` sign-extended.
- R11: On a write access, `mem_wdata` equals `st_data`, and `opnd_valid` is low in the next cycle.
- R12: Configuration writes to `cfg_addr` 6 and 7 change neither the pointer, the strides nor the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write value |
| acc_req | input | 1 | Access request |
| acc_wr | input | 1 | Access is a store (1) or a fetch (0) |
| acc_sel | input | 2 | Stride select for the post-update |
| st_data | input | 32 | Datapath data to store |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_re` |
| opnd_valid | output | 1 | Formatted operand valid |
| opnd_data | output | 32 | Formatted two-lane operand |

## Verification
Seeded random mixes of configuration writes and accesses drive all four stride selects, including negative strides and configuration addresses that select nothing. Every generated address is compared with a pointer model, so a wrong select, a missing sign extension or a lost hold shows up as an address mismatch. Directed runs then cover specific cases:
- a pointer that wraps past 0xFFFF;
- a row-and-column walk, which tells a small-stride step apart from a row jump;
- pointer, stride and mode writes landing in the same cycle as an access, which separate bypass from one-cycle-late behaviour.

The memory returns address-dependent words with both signs in every byte. The four format modes then produce distinct results, so a lane swap, a zero extension or a replicate that picks the wrong element each gives a data mismatch.

// File: rtl/opnd_agu_pkg.sv
package opnd_agu_pkg;

  typedef struct packed {
    logic repl;
    logic widen;
  } fmt_mode_t;

endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs
  import opnd_agu_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned NUM_MOD = 4,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned CFG_AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0]  mod_sel,
  output logic [WORD_W-1:0] stride_o,
  output logic              ptr_we_o,
  output fmt_mode_t         mode_o
);

  localparam logic [CFG_AW-1:0] PTR_IDX  = CFG_AW'(NUM_MOD);
  localparam logic [CFG_AW-1:0] MODE_IDX = CFG_AW'(NUM_MOD + 1);

  logic [WORD_W-1:0] mod_q [NUM_MOD];
  logic [WORD_W-1:0] mod_eff [NUM_MOD];
  fmt_mode_t         mode_q, mode_d;
  logic              mode_en;

  genvar k;
  generate
    for (k = 0; k < NUM_MOD; k++) begin : g_mod
      logic              en;
      logic [WORD_W-1:0] d;
      always_comb begin
        en         = cfg_we && (cfg_addr == CFG_AW'(k));
        d          = cfg_wdata;
        mod_eff[k] = en ? cfg_wdata : mod_q[k];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mod_q[k] <= '0;
        else if (en) mod_q[k] <= d;
      end
    end
  endgenerate

  always_comb begin
    mode_en  = cfg_we && (cfg_addr == MODE_IDX);
    mode_d   = fmt_mode_t'(cfg_wdata[1:0]);
    mode_o   = mode_en ? mode_d : mode_q;
    ptr_we_o = cfg_we && (cfg_addr == PTR_IDX);
    stride_o = mod_eff[mod_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  // R5: a same-cycle stride write is visible to the access
  p_stride_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == CFG_AW'(mod_sel))) |-> (stride_o == cfg_wdata));

  // R12: unused configuration addresses leave the mode untouched
  p_unused_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr > MODE_IDX)) |=> $stable(mode_q));

endmodule

// File: rtl/agu_ptr_unit.sv
module agu_ptr_unit #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic [WORD_W-1:0] ptr_wdata,
  input  logic              acc,
  input  logic [WORD_W-1:0] stride,
  output logic [WORD_W-1:0] addr_o
);

  logic [WORD_W-1:0] ptr_q, ptr_d, base;
  logic              ptr_en;

  always_comb begin
    base   = ptr_we ? ptr_wdata : ptr_q;
    ptr_d  = acc ? (base + stride) : base;
    ptr_en = ptr_we || acc;
    addr_o = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R3: post-update by the selected stride, wrapping
  p_post_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (ptr_q == WORD_W'($past(addr_o) + $past(stride))));

  // R4: idle cycles hold the pointer
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !ptr_we) |=> $stable(ptr_q));

endmodule

// File: rtl/agu_fmt.sv
module agu_fmt #(
  parameter int unsigned ELEM_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic [LANES*ELEM_W-1:0] word_i,
  input  logic                    widen,
  input  logic                    repl,
  output logic [LANES*ELEM_W-1:0] opnd_o
);

  logic [ELEM_W-1:0] elem [LANES];

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      logic [BYTE_W-1:0] nb;
      logic [ELEM_W-1:0] narrow, full;
      always_comb begin
        nb      = word_i[l*BYTE_W +: BYTE_W];
        narrow  = {{(ELEM_W-BYTE_W){nb[BYTE_W-1]}}, nb};
        full    = word_i[l*ELEM_W +: ELEM_W];
        elem[l] = widen ? narrow : full;
      end
      assign opnd_o[l*ELEM_W +: ELEM_W] = repl ? elem[0] : elem[l];
    end
  endgenerate

endmodule

// File: rtl/opnd_agu.sv
module opnd_agu
  import opnd_agu_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned NUM_MOD = 4,
  parameter int unsigned ELEM_W  = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned LANES   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [$clog2(NUM_MOD+2)-1:0]       cfg_addr,
  input  logic [WORD_W-1:0]                  cfg_wdata,
  input  logic                               acc_req,
  input  logic                               acc_wr,
  input  logic [$clog2(NUM_MOD)-1:0]         acc_sel,
  input  logic [LANES*ELEM_W-1:0]            st_data,
  output logic [WORD_W-1:0]                  mem_addr,
  output logic                               mem_re,
  output logic                               mem_we,
  output logic [LANES*ELEM_W-1:0]            mem_wdata,
  input  logic [LANES*ELEM_W-1:0]            mem_rdata,
  output logic                               opnd_valid,
  output logic [LANES*ELEM_W-1:0]            opnd_data
);

  localparam int unsigned SEL_W  = $clog2(NUM_MOD);
  localparam int unsigned CFG_AW = $clog2(NUM_MOD + 2);
  localparam int unsigned DATA_W = LANES * ELEM_W;

  logic [WORD_W-1:0] stride;
  logic              ptr_we;
  fmt_mode_t         mode_eff;

  agu_cfg_regs #(
    .WORD_W (WORD_W),
    .NUM_MOD(NUM_MOD),
    .SEL_W  (SEL_W),
    .CFG_AW (CFG_AW)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .mod_sel  (acc_sel),
    .stride_o (stride),
    .ptr_we_o (ptr_we),
    .mode_o   (mode_eff)
  );

  agu_ptr_unit #(.WORD_W(WORD_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_we   (ptr_we),
    .ptr_wdata(cfg_wdata),
    .acc      (acc_req),
    .stride   (stride),
    .addr_o   (mem_addr)
  );

  // read-return tracking
  logic      rd_pend_q, rd_pend_d;
  fmt_mode_t rd_mode_q, rd_mode_d;
  logic      rd_mode_en;

  always_comb begin
    mem_re     = acc_req && !acc_wr;
    mem_we     = acc_req && acc_wr;
    mem_wdata  = st_data;
    rd_pend_d  = mem_re;
    rd_mode_en = mem_re;
    rd_mode_d  = mode_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_mode_q <= '0;
    end else begin
      rd_pend_q <= rd_pend_d;
      if (rd_mode_en) rd_mode_q <= rd_mode_d;
    end
  end

  agu_fmt #(
    .ELEM_W(ELEM_W),
    .BYTE_W(BYTE_W),
    .LANES (LANES)
  ) u_fmt (
    .word_i(mem_rdata),
    .widen (rd_mode_q.widen),
    .repl  (rd_mode_q.repl),
    .opnd_o(opnd_data)
  );

  assign opnd_valid = rd_pend_q;

  // R2: strobes are exclusive
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R6: each read yields a valid operand in the next cycle
  p_rd_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> opnd_valid);

  // R11: a store yields no operand
  p_wr_no_opnd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !opnd_valid);

  // R9: replication puts equal lanes out
  p_repl_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_valid && rd_mode_q.repl) |->
      (opnd_data[DATA_W-1 -: ELEM_W] == opnd_data[ELEM_W-1:0]));

  // R8: widened lane 0 carries its byte's sign in the upper bits
  p_widen_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_valid && rd_mode_q.widen) |->
      (opnd_data[ELEM_W-1:BYTE_W] == {(ELEM_W-BYTE_W){opnd_data[BYTE_W-1]}}));

endmodule

// File: tb/opnd_agu_tb.sv
module opnd_agu_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        acc_req, acc_wr;
  logic [1:0]  acc_sel;
  logic [31:0] st_data;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        opnd_valid;
  logic [31:0] opnd_data;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [15:0] m_ptr;
  logic [15:0] m_mod [4];
  logic [1:0]  m_mode;
  logic        m_pend;
  logic [31:0] m_opnd;

  always #(CLK_P/2) clk = ~clk;

  opnd_agu u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .st_data(st_data), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .opnd_valid(opnd_valid), .opnd_data(opnd_data)
  );

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a ^ 16'h5A3C, 16'(a * 16'd37) + 16'h8181};
  endfunction

  function automatic logic [15:0] sx8(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  // mode bit0 widen, bit1 replicate
  function automatic logic [31:0] fmtf(input logic [31:0] w, input logic [1:0] md);
    case (md)
      2'd0: return w;
      2'd1: return {sx8(w[15:8]), sx8(w[7:0])};
      2'd2: return {w[15:0], w[15:0]};
      default: return {sx8(w[7:0]), sx8(w[7:0])};
    endcase
  endfunction

  // synchronous memory: data one cycle after the address
  always_ff @(posedge clk) mem_rdata <= memf(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // one cycle: check last read's operand, drive, check address path, update model
  task automatic step(input logic cw, input logic [2:0] ca, input logic [15:0] cd,
                      input logic ar, input logic aw, input logic [1:0] as,
                      input logic [31:0] sd);
    logic [15:0] addr;
    @(negedge clk);
    chk("R6 opnd_valid", {31'b0, opnd_valid}, {31'b0, m_pend});
    if (m_pend) chk("R6-R10 opnd_data", opnd_data, m_opnd);
    cfg_we = cw; cfg_addr = ca; cfg_wdata = cd;
    acc_req = ar; acc_wr = aw; acc_sel = as; st_data = sd;
    if (cw) begin
      if (ca < 3'd4)       m_mod[ca[1:0]] = cd;
      else if (ca == 3'd4) m_ptr = cd;
      else if (ca == 3'd5) m_mode = cd[1:0];
    end
    #1;
    chk("R2 mem_re", {31'b0, mem_re}, {31'b0, ar && !aw});
    chk("R2 mem_we", {31'b0, mem_we}, {31'b0, ar && aw});
    m_pend = 1'b0;
    if (ar) begin
      addr = m_ptr;
      chk("R3/R5 mem_addr", {16'b0, mem_addr}, {16'b0, addr});
      if (aw) chk("R11 mem_wdata", mem_wdata, sd);
      else begin
        m_pend = 1'b1;
        m_opnd = fmtf(memf(addr), m_mode);
      end
      m_ptr = 16'(m_ptr + m_mod[as]);
    end
  endtask

  task automatic cfgw(input logic [2:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic rd(input logic [1:0] s);
    step(1'b0, 3'd0, 16'd0, 1'b1, 1'b0, s, 32'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    acc_req = 0; acc_wr = 0; acc_sel = 0; st_data = 0;
    m_ptr = 0; m_mode = 0; m_pend = 0; m_opnd = 0;
    for (int i = 0; i < 4; i++) m_mod[i] = 16'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mem_re", {31'b0, mem_re}, 32'd0);
    chk("R1 mem_we", {31'b0, mem_we}, 32'd0);
    chk("R1 opnd_valid", {31'b0, opnd_valid}, 32'd0);
    rst_n = 1'b1;
    // R1 first access at zero, zero stride keeps it there
    rd(2'd3);
    rd(2'd1);

    // R3 wrap past 0xFFFF and negative stride
    cfgw(3'd4, 16'hFFFE);
    cfgw(3'd0, 16'd3);
    cfgw(3'd1, 16'hFFFE);
    rd(2'd0); rd(2'd0); rd(2'd1); rd(2'd1);

    // R4 idle cycles hold, then an access sees the same pointer
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    rd(2'd2);

    // R8 R7 R9 R10 under each mode; 2D walk with row stride
    cfgw(3'd4, 16'h0100);
    cfgw(3'd0, 16'd1);
    cfgw(3'd1, 16'd13);
    for (int md = 0; md < 4; md++) begin
      cfgw(3'd5, 16'(md));
      for (int c = 0; c < 3; c++) rd(2'd0);
      rd(2'd1);
    end

    // R5 same-cycle pointer, stride and mode writes win over stored values
    step(1, 3'd4, 16'h4000, 1, 0, 2'd0, 0);
    step(1, 3'd2, 16'h0040, 1, 0, 2'd2, 0);
    step(1, 3'd5, 16'd2, 1, 0, 2'd2, 0);
    rd(2'd0);

    // R12 unused config addresses ignored
    cfgw(3'd6, 16'h1234);
    cfgw(3'd7, 16'hBEEF);
    rd(2'd2); rd(2'd0);

    // R11 stores
    step(0, 0, 0, 1, 1, 2'd2, 32'hCAFE_F00D);
    rd(2'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], 3'(r[4:2]), 16'($urandom), r[5] | r[6],
           r[7] & r[8], 2'(r[10:9]), $urandom);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule